// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Integer Core

This block is a small 32-bit processor core that completes one instruction per clock. A program counter, a 32 x 32-bit register file, an instruction decoder and an ALU sit around two memory ports. The instruction port outputs a word address and takes back a 32-bit instruction word in the same cycle. The data port outputs a byte address, write data and a write strobe, and takes back read data combinationally.

The core decodes three instruction layouts. The register layout holds two sources, a destination, a shift field and a function code. The immediate layout holds two register fields and a 16-bit constant. The jump layout holds a 26-bit target field. The core supports register add, subtract and signed set-less-than, and immediate add, set-less-than, and, or, and upper load. It also supports word load and store, branch on equal and not-equal relative to the next PC, and region-preserving jumps. A 32-bit constant is built in two steps: an upper-immediate load followed by an immediate or.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the fetch word address is 0, and after release the first instruction is fetched from word 0.
- R2: Opcode 0 with shift field 0 and function code 32, 34 or 42 writes rs+rt, rs-rt or (signed rs < signed rt ? 1 : 0) into register rd (bits 15:11). rs is bits 25:21, rt is bits 20:16 and the function code is bits 5:0.
- R3: Opcodes 8 (add) and 10 (signed set-less-than) sign-extend the 16-bit immediate (bits 15:0). Opcodes 12 (and) and 13 (or) zero-extend it. All four write their result into rt.
- R4: Opcode 15 writes the immediate into the upper 16 bits of rt and clears the lower 16 bits. Together with opcode 13 it loads any 32-bit constant.
- R5: Opcode 35 loads the word at byte address rs + sign-extended offset into rt. Opcode 43 writes rt to that address, raising `dmem_we` only in that cycle, and changes no register, whatever bits 15:11 hold.
- R6: Opcode 4 (equal) and opcode 5 (not equal) compare rs with rt. A taken branch continues at PC+4 + (sign-extended immediate << 2). A branch not taken continues at PC+4.
- R7: Opcode 2 continues at {PC+4 bits 31:28, field bits 25:0, 00}.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: An unlisted opcode, an unlisted function code, or a register-layout word with a nonzero shift field writes no register and no memory, and advances the PC by 4.
- R10: The fetch word address equals PC/4. Each clock edge after reset retires exactly one instruction, and every instruction other than a taken branch or a jump advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ifetch_waddr | output | 30 | Word address of the instruction being fetched |
| ifetch_instr | input | 32 | Instruction word at `ifetch_waddr`, same cycle |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by memory at the rising edge |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, same cycle |

## Verification
Every result lands at the rising edge that closes its instruction's cycle. A register write becomes visible to the next instruction, a store updates memory at that same edge, and `ifetch_waddr` moves to the successor address one edge after the instruction was presented. The bench samples on the falling edge. It compares the fetch address cycle by cycle against the expected control-flow trace. Register results are read out through stores, and memory is compared only after the program has parked in a self-jump, when no further write can be pending.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_JMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_BNE  = 6'd5;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_SLTI = 6'd10;
  localparam logic [5:0] OPC_ANDI = 6'd12;
  localparam logic [5:0] OPC_ORI  = 6'd13;
  localparam logic [5:0] OPC_LUI  = 6'd15;
  localparam logic [5:0] OPC_LDW  = 6'd35;
  localparam logic [5:0] OPC_STW  = 6'd43;

  localparam logic [5:0] FC_ADD = 6'd32;
  localparam logic [5:0] FC_SUB = 6'd34;
  localparam logic [5:0] FC_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_AND,
    ALU_OR,
    ALU_UPR
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    use_imm;
    logic    imm_sext;
    logic    reg_we;
    logic    dst_is_rd;
    logic    load;
    logic    store;
    logic    branch;
    logic    branch_ne;
    logic    jump;
    logic    illegal;
  } ctrl_t;

endpackage

// File: rtl/sc_core_decode.sv
module sc_core_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_REG: begin
        if (shamt != 5'd0) begin
          ctrl.illegal = 1'b1;
        end else begin
          unique case (funct)
            FC_ADD: begin ctrl.alu_op = ALU_ADD; ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; end
            FC_SUB: begin ctrl.alu_op = ALU_SUB; ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; end
            FC_SLT: begin ctrl.alu_op = ALU_SLT; ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; end
            default: ctrl.illegal = 1'b1;
          endcase
        end
      end
      OPC_LDW: begin
        ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1; ctrl.reg_we = 1'b1; ctrl.load = 1'b1;
      end
      OPC_STW: begin
        ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1; ctrl.store = 1'b1;
      end
      OPC_BEQ: ctrl.branch = 1'b1;
      OPC_BNE: begin ctrl.branch = 1'b1; ctrl.branch_ne = 1'b1; end
      OPC_JMP: ctrl.jump = 1'b1;
      OPC_ADDI: begin
        ctrl.alu_op = ALU_ADD; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1; ctrl.reg_we = 1'b1;
      end
      OPC_SLTI: begin
        ctrl.alu_op = ALU_SLT; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1; ctrl.reg_we = 1'b1;
      end
      OPC_ANDI: begin
        ctrl.alu_op = ALU_AND; ctrl.use_imm = 1'b1; ctrl.reg_we = 1'b1;
      end
      OPC_ORI: begin
        ctrl.alu_op = ALU_OR; ctrl.use_imm = 1'b1; ctrl.reg_we = 1'b1;
      end
      OPC_LUI: begin
        ctrl.alu_op = ALU_UPR; ctrl.use_imm = 1'b1; ctrl.reg_we = 1'b1;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam int HALF = W / 2;

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_UPR: y = {b[HALF-1:0], {HALF{1'b0}}};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/sc_core_regfile.sv
module sc_core_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2
);

  localparam int AW = $clog2(NREG);

  logic [W-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign regs_q[i] = '0;
    end else begin : g_reg
      logic ent_en;
      assign ent_en = we && (wa == AW'(i));
      always_ff @(posedge clk) begin
        if (ent_en) regs_q[i] <= wd;
      end
    end
  end

  assign rd1 = regs_q[ra1];
  assign rd2 = regs_q[ra2];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [29:0] ifetch_waddr,
  input  logic [31:0] ifetch_instr,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);

  localparam int W  = 32;
  localparam int AW = $clog2(NREG);
  localparam int PW = W - 2;

  // program counter, held as a word address
  logic [PW-1:0] pc_q, pc_d, pc_inc, pc_br, pc_jmp;

  // instruction fields
  logic [5:0]    opcode, funct;
  logic [4:0]    shamt;
  logic [AW-1:0] rs_idx, rt_idx, rd_idx;
  logic [15:0]   imm16;
  logic [W-1:0]  imm_sx, imm_zx, imm_ext;

  ctrl_t         ctrl;
  logic [W-1:0]  rs_val, rt_val, alu_b, alu_y, wb_data;
  logic          rf_we, br_take;
  logic [AW-1:0] rf_wa;

  assign opcode = ifetch_instr[31:26];
  assign rs_idx = ifetch_instr[25:21];
  assign rt_idx = ifetch_instr[20:16];
  assign rd_idx = ifetch_instr[15:11];
  assign shamt  = ifetch_instr[10:6];
  assign funct  = ifetch_instr[5:0];
  assign imm16  = ifetch_instr[15:0];

  assign imm_sx  = {{(W-16){imm16[15]}}, imm16};
  assign imm_zx  = {{(W-16){1'b0}}, imm16};
  assign imm_ext = ctrl.imm_sext ? imm_sx : imm_zx;

  sc_core_decode u_dec (
    .opcode (opcode),
    .shamt  (shamt),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  sc_core_regfile #(.NREG(NREG), .W(W)) u_rf (
    .clk (clk),
    .we  (rf_we),
    .wa  (rf_wa),
    .wd  (wb_data),
    .ra1 (rs_idx),
    .ra2 (rt_idx),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

  sc_core_alu #(.W(W)) u_alu (
    .op (ctrl.alu_op),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y)
  );

  // write-back and memory side
  assign rf_we      = ctrl.reg_we;
  assign rf_wa      = ctrl.dst_is_rd ? rd_idx : rt_idx;
  assign wb_data    = ctrl.load ? dmem_rdata : alu_y;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.store;

  // next-PC selection
  assign br_take = ctrl.branch && ((rs_val == rt_val) != ctrl.branch_ne);
  assign pc_inc  = pc_q + PW'(1);
  assign pc_br   = pc_inc + imm_sx[PW-1:0];
  assign pc_jmp  = {pc_inc[PW-1:26], ifetch_instr[25:0]};

  always_comb begin
    if (ctrl.jump)   pc_d = pc_jmp;
    else if (br_take) pc_d = pc_br;
    else             pc_d = pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC[W-1:2];
    else        pc_q <= pc_d;
  end

  assign ifetch_waddr = pc_q;

  // ---------------------------------------------------------------- checks
  p_fetch_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.jump && !ctrl.branch) |=> (ifetch_waddr == $past(ifetch_waddr) + 30'd1));

  p_branch_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.branch && ((rs_val == rt_val) != ctrl.branch_ne))
      |=> (ifetch_waddr == $past(ifetch_waddr) + 30'd1 + $past(imm_sx[PW-1:0])));

  p_branch_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.branch && ((rs_val == rt_val) == ctrl.branch_ne))
      |=> (ifetch_waddr == $past(ifetch_waddr) + 30'd1));

  p_jump_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.jump |=> (ifetch_waddr[25:0] == $past(ifetch_instr[25:0])));

  p_jump_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.jump |=> (ifetch_waddr[PW-1:26] == $past(pc_inc[PW-1:26])));

  p_r0_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_idx == '0) |-> (rs_val == '0));

  p_noop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.illegal |-> (!dmem_we && !rf_we));

endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

  localparam logic [31:0] PAT = 32'hDEAD_BEEF;
  localparam int          WD  = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_mem;
  logic [29:0] ifetch_waddr;
  logic [31:0] ifetch_instr, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int errors = 0;
  int pcnt   = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sc_core dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ifetch_waddr (ifetch_waddr),
    .ifetch_instr (ifetch_instr),
    .dmem_addr    (dmem_addr),
    .dmem_wdata   (dmem_wdata),
    .dmem_we      (dmem_we),
    .dmem_rdata   (dmem_rdata)
  );

  assign ifetch_instr = imem[ifetch_waddr[5:0]];
  assign dmem_rdata   = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (clr_mem) begin
      for (int i = 0; i < 64; i++) dmem[i] <= PAT;
    end else if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
    end
  end

  // ---------------------------------------------------------------- encoders
  function automatic logic [31:0] e_r(logic [5:0] fc, logic [4:0] rs, logic [4:0] rt,
                                      logic [4:0] rd, logic [4:0] sh);
    return {6'd0, rs, rt, rd, sh, fc};
  endfunction

  function automatic logic [31:0] e_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                      logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] e_j(logic [25:0] t);
    return {6'd2, t};
  endfunction

  task automatic put(logic [31:0] w);
    imem[pcnt] = w;
    pcnt++;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // hold reset, clear memory, fill the program store with self-jumps
  task automatic hold_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    clr_mem = 1'b1;
    for (int i = 0; i < 64; i++) imem[i] = e_j(26'(i));
    pcnt = 0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    @(negedge clk);
    chk("R1 fetch during reset", {2'b0, ifetch_waddr}, 32'd0);
    clr_mem = 1'b0;
    rst_n   = 1'b1;
    #1;
    chk("R1 first fetch after release", {2'b0, ifetch_waddr}, 32'd0);
  endtask

  // ---------------------------------------------------------------- tests
  task automatic alu_pair(logic [31:0] a, logic [31:0] b);
    logic [31:0] sx, zx;
    logic [31:0] exp [11];
    sx = {{16{b[15]}}, b[15:0]};
    zx = {16'd0, b[15:0]};
    hold_reset();
    put(e_i(6'd15, 5'd0, 5'd1, a[31:16]));
    put(e_i(6'd13, 5'd1, 5'd1, a[15:0]));
    put(e_i(6'd15, 5'd0, 5'd2, b[31:16]));
    put(e_i(6'd13, 5'd2, 5'd2, b[15:0]));
    put(e_r(6'd32, 5'd1, 5'd2, 5'd3, 5'd0));
    put(e_r(6'd34, 5'd1, 5'd2, 5'd4, 5'd0));
    put(e_r(6'd42, 5'd1, 5'd2, 5'd5, 5'd0));
    put(e_i(6'd8,  5'd1, 5'd6,  b[15:0]));
    put(e_i(6'd10, 5'd1, 5'd7,  b[15:0]));
    put(e_i(6'd12, 5'd1, 5'd8,  b[15:0]));
    put(e_i(6'd13, 5'd1, 5'd9,  b[15:0]));
    put(e_i(6'd15, 5'd0, 5'd10, b[15:0]));
    for (int k = 1; k <= 10; k++) put(e_i(6'd43, 5'd0, 5'(k), 16'(k * 4)));
    put(e_j(26'(pcnt)));
    release_reset();
    repeat (26) @(negedge clk);
    exp[1]  = a;
    exp[2]  = b;
    exp[3]  = a + b;
    exp[4]  = a - b;
    exp[5]  = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    exp[6]  = a + sx;
    exp[7]  = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
    exp[8]  = a & zx;
    exp[9]  = a | zx;
    exp[10] = {b[15:0], 16'd0};
    chk("R4 constant via upper+or (a)", dmem[1], exp[1]);
    chk("R4 constant via upper+or (b)", dmem[2], exp[2]);
    chk("R2 add", dmem[3], exp[3]);
    chk("R2 sub", dmem[4], exp[4]);
    chk("R2 slt signed", dmem[5], exp[5]);
    chk("R3 addi sign-extend", dmem[6], exp[6]);
    chk("R3 slti sign-extend", dmem[7], exp[7]);
    chk("R3 andi zero-extend", dmem[8], exp[8]);
    chk("R3 ori zero-extend", dmem[9], exp[9]);
    chk("R4 upper immediate", dmem[10], exp[10]);
  endtask

  task automatic mem_test();
    hold_reset();
    put(e_i(6'd8,  5'd0, 5'd1, 16'd100));
    put(e_i(6'd15, 5'd0, 5'd2, 16'hCAFE));
    put(e_i(6'd13, 5'd2, 5'd2, 16'hF00D));
    put(e_i(6'd43, 5'd1, 5'd2, 16'hFFF8));
    put(e_i(6'd35, 5'd1, 5'd3, 16'hFFF8));
    put(e_i(6'd43, 5'd1, 5'd3, 16'd4));
    put(e_i(6'd8,  5'd0, 5'd5, 16'h0055));
    put(e_i(6'd8,  5'd0, 5'd6, 16'h0030));
    put(e_i(6'd43, 5'd6, 5'd2, 16'h2800));
    put(e_i(6'd43, 5'd0, 5'd5, 16'd0));
    put(e_i(6'd35, 5'd6, 5'd7, 16'h2800));
    put(e_i(6'd43, 5'd0, 5'd7, 16'd4));
    put(e_j(26'(pcnt)));
    release_reset();
    repeat (16) @(negedge clk);
    chk("R5 store at negative offset", dmem[23], 32'hCAFE_F00D);
    chk("R5 load at negative offset", dmem[26], 32'hCAFE_F00D);
    chk("R5 store with rd bits set", dmem[12], 32'hCAFE_F00D);
    chk("R5 store left rd register alone", dmem[0], 32'h0000_0055);
    chk("R5 load with large offset", dmem[1], 32'hCAFE_F00D);
  endtask

  task automatic flow_test();
    int trace [24] = '{1, 2, 4, 5, 6, 7, 8, 11, 12, 13, 16, 17,
                       18, 19, 17, 18, 19, 17, 18, 19, 20, 21, 21, 21};
    hold_reset();
    put(e_i(6'd8, 5'd0, 5'd1, 16'd7));
    put(e_i(6'd8, 5'd0, 5'd2, 16'd7));
    put(e_i(6'd4, 5'd1, 5'd2, 16'd1));
    put(e_i(6'd43, 5'd0, 5'd1, 16'd0));
    put(e_i(6'd5, 5'd1, 5'd2, 16'd1));
    put(e_i(6'd8, 5'd0, 5'd3, 16'h0033));
    put(e_i(6'd43, 5'd0, 5'd3, 16'd4));
    put(e_i(6'd8, 5'd0, 5'd4, 16'hFFFF));
    put(e_i(6'd5, 5'd1, 5'd4, 16'd2));
    put(e_i(6'd43, 5'd0, 5'd1, 16'd8));
    put(e_i(6'd43, 5'd0, 5'd1, 16'd8));
    put(e_i(6'd4, 5'd1, 5'd4, 16'd1));
    put(e_i(6'd43, 5'd0, 5'd4, 16'd12));
    put(e_j(26'd16));
    put(e_i(6'd43, 5'd0, 5'd1, 16'd16));
    put(e_i(6'd43, 5'd0, 5'd1, 16'd16));
    put(e_i(6'd8, 5'd0, 5'd6, 16'd0));
    put(e_i(6'd8, 5'd6, 5'd6, 16'd1));
    put(e_i(6'd10, 5'd6, 5'd7, 16'd3));
    put(e_i(6'd5, 5'd7, 5'd0, 16'hFFFD));
    put(e_i(6'd43, 5'd0, 5'd6, 16'd20));
    put(e_j(26'd21));
    release_reset();
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      chk("R6 R7 fetch trace", {2'b0, ifetch_waddr}, 32'(trace[k]));
    end
    chk("R6 beq taken skips store", dmem[0], PAT);
    chk("R6 bne not taken falls through", dmem[1], 32'h0000_0033);
    chk("R6 bne taken skips stores", dmem[2], PAT);
    chk("R6 beq not taken falls through", dmem[3], 32'hFFFF_FFFF);
    chk("R7 jump skips stores", dmem[4], PAT);
    chk("R6 backward branch loop count", dmem[5], 32'd3);
  endtask

  task automatic noop_test();
    hold_reset();
    put(e_i(6'd8, 5'd0, 5'd1, 16'h0011));
    put(e_i(6'h3F, 5'd0, 5'd1, 16'd4));
    put(e_i(6'h2A, 5'd0, 5'd1, 16'd8));
    put(e_r(6'h21, 5'd0, 5'd0, 5'd1, 5'd0));
    put(e_r(6'd32, 5'd0, 5'd0, 5'd1, 5'd3));
    put(e_i(6'd8, 5'd0, 5'd0, 16'd5));
    put(e_i(6'd13, 5'd0, 5'd0, 16'h00FF));
    put(e_i(6'd43, 5'd0, 5'd1, 16'd0));
    put(e_i(6'd43, 5'd0, 5'd0, 16'd4));
    put(e_j(26'd9));
    release_reset();
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      chk("R9 R10 sequential fetch", {2'b0, ifetch_waddr}, 32'(k));
    end
    repeat (3) @(negedge clk);
    chk("R9 unlisted codes left register alone", dmem[0], 32'h0000_0011);
    chk("R8 register 0 reads zero after writes", dmem[1], 32'd0);
    chk("R9 unlisted opcode wrote no memory", dmem[2], PAT);
  endtask

  // ---------------------------------------------------------------- main
  initial begin
    logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h0000_8000, 32'h1234_5678, 32'hFFFF_7FFE};
    rst_n   = 1'b0;
    clr_mem = 1'b1;
    for (int i = 0; i < 64; i++) imem[i] = e_j(26'(i));
    noop_test();
    mem_test();
    flow_test();
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) alu_pair(vals[i], vals[j]);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule